// File: doc/BRIEF.md
# Dual-Timer Register Bank

This block holds the six 8-bit registers of a controller with two timers, A and B. The registers are a shared control register, a shared mode register, and a low and a high count register for each timer. A 32-bit host reads and writes them through classic single-transfer Wishbone cycles. Only data lane 7..0 carries register contents.

The timer core sits beside the bank. Every clock it drives the control register's lower nibble from a status input. Through load strobes it can also replace count values and raise the two overflow flags. When the host and the core target the same register in the same clock, the host write wins.

Two host writes are shaped rather than copied. A write to a timer's low count register keeps only five bits while that timer is in mode 0. A write to the control register reaches only its upper nibble.

Top module: `dtmr_regbank`

## Requirements
- R1: A synchronous reset clears all six registers to zero and holds the acknowledge low.
- R2: The acknowledge rises for exactly one clock in response to each request with cycle and strobe both high. It never rises while strobe is low.
- R3: A host write to the control register (offset 0) replaces only bits 7..4 with data bits 7..4. Bits 3..0 follow the 4-bit status input, sampled on every clock.
- R4: A host write to the mode register (offset 1) stores all eight data bits. Timer A's mode is mode bits 1..0 and timer B's mode is mode bits 5..4; the codes 00, 01, 10 and 11 select modes 0 to 3.
- R5: While a timer's mode field is 00, a host write to its low count register (A at offset 2, B at offset 3) stores data bits 4..0 and clears bits 7..5.
- R6: While a timer's mode field is 01, 10 or 11, a host write to its low count register stores all eight bits. The mask uses the mode held before the write.
- R7: A host write to either high count register (A at offset 4, B at offset 5) stores all eight bits.
- R8: A read returns the addressed register on data bits 7..0 and zero on bits 31..8, valid while the acknowledge is high. The offset is byte address bits 4..2.
- R9: Offsets 6 and 7 read as zero, and writes to them change no register.
- R10: A core load strobe for a timer replaces that timer's low or high count with the supplied byte. A core flag-set input sets control bit 5 for timer A and control bit 7 for timer B.
- R11: When a host write and a core load or flag set hit the same register in the same clock, the host value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc | input | 1 | Bus cycle in progress |
| wb_stb | input | 1 | Transfer request strobe |
| wb_we | input | 1 | 1 = write, 0 = read |
| wb_adr | input | ADR_W | Byte address; bits ADR_W-1..2 select the register |
| wb_wdata | input | 32 | Write data, low byte used |
| wb_rdata | output | 32 | Registered read data |
| wb_ack | output | 1 | One-clock transfer acknowledge |
| core_status | input | 4 | Value loaded into control bits 3..0 each clock |
| core_flag_set | input | 2 | Per-timer overflow flag set (bit 0 = A, bit 1 = B) |
| core_lo_load | input | 2 | Per-timer low count load strobe |
| core_lo_val | input | 16 | Low count values, timer t in bits 8t+7..8t |
| core_hi_load | input | 2 | Per-timer high count load strobe |
| core_hi_val | input | 16 | High count values, timer t in bits 8t+7..8t |

## Verification
The bench builds the bank with its default ADR_W of 5. That gives three offset bits, so offsets 6 and 7 can be reached and the unused decode space is exercised alongside all six registers. The mode register is swept so that each timer sees mode 0 and at least one other mode when its low count is written. Core strobes are raised in the same clock as host writes, which puts the same-clock priority rule within reach.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    localparam int REG_W      = 8;
    localparam int NUM_REGS   = 6;
    localparam int NUM_TIMERS = 2;
    localparam int NARROW_W   = 5;
    localparam int LO_BASE    = 2;
    localparam int HI_BASE    = 4;
    localparam int MODE_STRIDE = 4;
    localparam int NIB_W      = REG_W / 2;

    typedef enum logic [2:0] {
        OFF_CTRL = 3'd0,
        OFF_MODE = 3'd1,
        OFF_LO_A = 3'd2,
        OFF_LO_B = 3'd3,
        OFF_HI_A = 3'd4,
        OFF_HI_B = 3'd5
    } reg_off_e;

    typedef enum logic [1:0] {
        TM_0 = 2'd0,
        TM_1 = 2'd1,
        TM_2 = 2'd2,
        TM_3 = 2'd3
    } tmode_e;

    // Position of timer t's overflow flag inside the control upper nibble
    function automatic int flag_nib_pos(input int t);
        return 2 * t + 1;
    endfunction

    // Value stored by a host write to a low count register
    function automatic logic [REG_W-1:0] lo_write_val(input tmode_e m,
                                                      input logic [REG_W-1:0] d);
        logic [REG_W-1:0] v;
        if (m == TM_0) v = {{(REG_W-NARROW_W){1'b0}}, d[NARROW_W-1:0]};
        else           v = d;
        return v;
    endfunction

endpackage

// File: rtl/dtmr_bus_if.sv
module dtmr_bus_if
    import dtmr_pkg::*;
#(
    parameter int ADR_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cyc,
    input  logic                      stb,
    input  logic                      we,
    input  logic [ADR_W-1:0]          adr,
    input  logic [NUM_REGS*REG_W-1:0] reg_flat,
    output logic                      ack,
    output logic [DATA_W-1:0]         rdata,
    output logic [NUM_REGS-1:0]       wr_stb
);
    localparam int OFF_W = ADR_W - 2;

    logic             accept;
    logic [OFF_W-1:0] off;
    logic [REG_W-1:0] rd_byte;

    assign accept = cyc && stb && !ack;
    assign off    = adr[ADR_W-1:2];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
        assign wr_stb[i] = accept && we && (off == OFF_W'(i));
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (off == OFF_W'(i)) rd_byte = reg_flat[i*REG_W +: REG_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack   <= 1'b0;
            rdata <= '0;
        end else begin
            ack <= accept;
            if (accept && !we) rdata <= DATA_W'(rd_byte);
        end
    end

    // R2
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);
    // R2
    ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(cyc && stb));
    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_stb));

endmodule

// File: rtl/dtmr_ctrl_reg.sv
module dtmr_ctrl_reg
    import dtmr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_we,
    input  logic [NIB_W-1:0]      host_nib,
    input  logic [NIB_W-1:0]      status,
    input  logic [NUM_TIMERS-1:0] flag_set,
    output logic [REG_W-1:0]      q
);
    logic [NIB_W-1:0] hi_q;
    logic [NIB_W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            lo_q <= status;
            if (host_we) begin
                hi_q <= host_nib;
            end else begin
                for (int t = 0; t < NUM_TIMERS; t++) begin
                    if (flag_set[t]) hi_q[flag_nib_pos(t)] <= 1'b1;
                end
            end
        end
    end

    assign q = {hi_q, lo_q};

    // R3
    ctrl_host_chk: assert property (@(posedge clk) disable iff (rst)
        host_we |=> q[REG_W-1:NIB_W] == $past(host_nib));
    // R10
    flag_a_chk: assert property (@(posedge clk) disable iff (rst)
        (!host_we && flag_set[0]) |=> q[5]);
    // R10
    flag_b_chk: assert property (@(posedge clk) disable iff (rst)
        (!host_we && flag_set[1]) |=> q[7]);

endmodule

// File: rtl/dtmr_count_reg.sv
module dtmr_count_reg
    import dtmr_pkg::*;
#(
    parameter bit IS_LOW = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic             host_we,
    input  logic [REG_W-1:0] host_data,
    input  logic             core_we,
    input  logic [REG_W-1:0] core_data,
    output logic [REG_W-1:0] q
);
    logic [REG_W-1:0] host_val;

    if (IS_LOW) begin : g_low
        assign host_val = lo_write_val(tmode_e'(mode), host_data);

        // R5
        lo_narrow_chk: assert property (@(posedge clk) disable iff (rst)
            (host_we && mode == 2'b00) |=> q[REG_W-1:NARROW_W] == '0);
        // R6
        lo_wide_chk: assert property (@(posedge clk) disable iff (rst)
            (host_we && mode != 2'b00) |=> q == $past(host_data));
    end else begin : g_high
        assign host_val = host_data;

        // R7
        hi_full_chk: assert property (@(posedge clk) disable iff (rst)
            host_we |=> q == $past(host_data));
    end

    always_ff @(posedge clk) begin
        if (rst)          q <= '0;
        else if (host_we) q <= host_val;
        else if (core_we) q <= core_data;
    end

    // R10
    core_load_chk: assert property (@(posedge clk) disable iff (rst)
        (core_we && !host_we) |=> q == $past(core_data));

endmodule

// File: rtl/dtmr_regbank.sv
module dtmr_regbank
    import dtmr_pkg::*;
#(
    parameter int ADR_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wb_cyc,
    input  logic                        wb_stb,
    input  logic                        wb_we,
    input  logic [ADR_W-1:0]            wb_adr,
    input  logic [DATA_W-1:0]           wb_wdata,
    output logic [DATA_W-1:0]           wb_rdata,
    output logic                        wb_ack,
    input  logic [NIB_W-1:0]            core_status,
    input  logic [NUM_TIMERS-1:0]       core_flag_set,
    input  logic [NUM_TIMERS-1:0]       core_lo_load,
    input  logic [NUM_TIMERS*REG_W-1:0] core_lo_val,
    input  logic [NUM_TIMERS-1:0]       core_hi_load,
    input  logic [NUM_TIMERS*REG_W-1:0] core_hi_val
);
    logic [NUM_REGS-1:0]       wr_stb;
    logic [REG_W-1:0]          regs [NUM_REGS];
    logic [NUM_REGS*REG_W-1:0] reg_flat;
    logic [REG_W-1:0]          wbyte;
    logic [REG_W-1:0]          mode_q;

    assign wbyte = wb_wdata[REG_W-1:0];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_flat
        assign reg_flat[i*REG_W +: REG_W] = regs[i];
    end

    dtmr_bus_if #(.ADR_W(ADR_W), .DATA_W(DATA_W)) u_bus (
        .clk      (clk),
        .rst      (rst),
        .cyc      (wb_cyc),
        .stb      (wb_stb),
        .we       (wb_we),
        .adr      (wb_adr),
        .reg_flat (reg_flat),
        .ack      (wb_ack),
        .rdata    (wb_rdata),
        .wr_stb   (wr_stb)
    );

    dtmr_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .host_we  (wr_stb[OFF_CTRL]),
        .host_nib (wbyte[REG_W-1:NIB_W]),
        .status   (core_status),
        .flag_set (core_flag_set),
        .q        (regs[OFF_CTRL])
    );

    always_ff @(posedge clk) begin
        if (rst)                   mode_q <= '0;
        else if (wr_stb[OFF_MODE]) mode_q <= wbyte;
    end
    assign regs[OFF_MODE] = mode_q;

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
        dtmr_count_reg #(.IS_LOW(1'b1)) u_lo (
            .clk       (clk),
            .rst       (rst),
            .mode      (mode_q[t*MODE_STRIDE +: 2]),
            .host_we   (wr_stb[LO_BASE+t]),
            .host_data (wbyte),
            .core_we   (core_lo_load[t]),
            .core_data (core_lo_val[t*REG_W +: REG_W]),
            .q         (regs[LO_BASE+t])
        );
        dtmr_count_reg #(.IS_LOW(1'b0)) u_hi (
            .clk       (clk),
            .rst       (rst),
            .mode      (mode_q[t*MODE_STRIDE +: 2]),
            .host_we   (wr_stb[HI_BASE+t]),
            .host_data (wbyte),
            .core_we   (core_hi_load[t]),
            .core_data (core_hi_val[t*REG_W +: REG_W]),
            .q         (regs[HI_BASE+t])
        );
    end

    // R1
    reset_ack_chk: assert property (@(posedge clk)
        $past(rst) |-> !wb_ack);

endmodule

// File: tb/dtmr_regbank_bench.sv
`timescale 1ns/1ps
module dtmr_regbank_bench;

    typedef struct {
        bit          is_read;
        logic [31:0] exp;
        int          off;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
    logic [4:0]  wb_adr = '0;
    logic [31:0] wb_wdata = '0;
    logic [31:0] wb_rdata;
    logic        wb_ack;
    logic [3:0]  core_status = '0;
    logic [1:0]  core_flag_set = '0, core_lo_load = '0, core_hi_load = '0;
    logic [15:0] core_lo_val = '0, core_hi_val = '0;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;
    bit ack_prev = 1'b0;
    item_t q_exp[$];

    logic [3:0] m_hi = '0;
    logic [7:0] m_reg [6];

    always #2 clk = ~clk;

    dtmr_regbank u_dtmr_regbank (
        .clk(clk), .rst(rst), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
        .wb_adr(wb_adr), .wb_wdata(wb_wdata), .wb_rdata(wb_rdata), .wb_ack(wb_ack),
        .core_status(core_status), .core_flag_set(core_flag_set),
        .core_lo_load(core_lo_load), .core_lo_val(core_lo_val),
        .core_hi_load(core_hi_load), .core_hi_val(core_hi_val)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input int off);
        logic [31:0] v;
        v = '0;
        if (off == 0)               v[7:0] = {m_hi, core_status};
        else if (off >= 1 && off <= 5) v[7:0] = m_reg[off];
        return v;
    endfunction

    // Monitor: pops one expected item per acknowledge
    always @(negedge clk) begin
        if (!rst) begin
            if (wb_ack && ack_prev) check("R2 ack width", 32'd2, 32'd1);
            if (wb_ack) begin
                if (q_exp.size() == 0) begin
                    check("R2 unexpected ack", 32'd1, 32'd0);
                end else begin
                    item_t it;
                    it = q_exp.pop_front();
                    if (it.is_read) check(it.req, wb_rdata, it.exp);
                end
            end
        end
        ack_prev = wb_ack;
    end

    task automatic bus_cycle(input bit we, input int off, input logic [7:0] d,
                             input logic [1:0] lo_ld, input logic [1:0] hi_ld,
                             input logic [1:0] flg, input logic [15:0] lo_v,
                             input logic [15:0] hi_v, input string req);
        item_t it;
        @(negedge clk);
        it.is_read = !we;
        it.off = off;
        it.req = req;
        it.exp = we ? 32'd0 : model_read(off);
        q_exp.push_back(it);
        if (we) begin
            for (int t = 0; t < 2; t++) begin
                if (lo_ld[t]) m_reg[2+t] = lo_v[t*8 +: 8];
                if (hi_ld[t]) m_reg[4+t] = hi_v[t*8 +: 8];
                if (flg[t])   m_hi[2*t+1] = 1'b1;
            end
            case (off)
                0: m_hi = d[7:4];
                1: m_reg[1] = d;
                2: m_reg[2] = (m_reg[1][1:0] == 2'b00) ? {3'b000, d[4:0]} : d;
                3: m_reg[3] = (m_reg[1][5:4] == 2'b00) ? {3'b000, d[4:0]} : d;
                4, 5: m_reg[off] = d;
                default: ;
            endcase
        end
        wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = we;
        wb_adr = 5'(off << 2); wb_wdata = {24'hA5A5A5, d};
        core_lo_load = lo_ld; core_hi_load = hi_ld; core_flag_set = flg;
        core_lo_val = lo_v; core_hi_val = hi_v;
        @(posedge clk);
        @(negedge clk);
        wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0;
        core_lo_load = '0; core_hi_load = '0; core_flag_set = '0;
    endtask

    task automatic wr(input int off, input logic [7:0] d);
        bus_cycle(1'b1, off, d, 2'b00, 2'b00, 2'b00, 16'h0, 16'h0, "write");
    endtask

    task automatic rd(input int off, input string req);
        bus_cycle(1'b0, off, 8'h00, 2'b00, 2'b00, 2'b00, 16'h0, 16'h0, req);
    endtask

    task automatic core_pulse(input logic [1:0] lo_ld, input logic [1:0] hi_ld,
                              input logic [1:0] flg, input logic [15:0] lo_v,
                              input logic [15:0] hi_v);
        @(negedge clk);
        for (int t = 0; t < 2; t++) begin
            if (lo_ld[t]) m_reg[2+t] = lo_v[t*8 +: 8];
            if (hi_ld[t]) m_reg[4+t] = hi_v[t*8 +: 8];
            if (flg[t])   m_hi[2*t+1] = 1'b1;
        end
        core_lo_load = lo_ld; core_hi_load = hi_ld; core_flag_set = flg;
        core_lo_val = lo_v; core_hi_val = hi_v;
        @(negedge clk);
        core_lo_load = '0; core_hi_load = '0; core_flag_set = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                check("watchdog", 32'd1, 32'd0);
                finish_run();
            end
        end
    end

    initial begin
        for (int i = 0; i < 6; i++) m_reg[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 ack in reset", {31'd0, wb_ack}, 32'd0);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) rd(i, "R1 reset value");

        // R2: cycle without strobe yields no acknowledge
        @(negedge clk);
        wb_cyc = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 no ack without stb", {31'd0, wb_ack}, 32'd0);
        wb_cyc = 1'b0;

        // R3: control upper nibble from host, lower from status
        core_status = 4'hA;
        repeat (2) @(negedge clk);
        wr(0, 8'h5F);
        rd(0, "R3 ctrl write");
        wr(0, 8'h30);
        core_status = 4'h6;
        repeat (2) @(negedge clk);
        rd(0, "R3 ctrl status");

        // R4 / R5 / R6: A mode 0, B mode 1
        wr(1, 8'h10);
        rd(1, "R4 mode");
        wr(2, 8'hFF);
        rd(2, "R5 A low narrow");
        wr(3, 8'hFF);
        rd(3, "R6 B low wide");
        // A mode 3, B mode 0; mask follows mode before write
        wr(1, 8'h03);
        wr(2, 8'hE5);
        rd(2, "R6 A low wide");
        wr(3, 8'hE5);
        rd(3, "R5 B low narrow");
        wr(1, 8'h22);
        wr(3, 8'hC9);
        rd(3, "R6 B low mode2");
        wr(2, 8'hF0);
        rd(2, "R6 A low mode2");

        // R7 high registers, R8 upper bits zero
        wr(4, 8'hC3);
        wr(5, 8'h3C);
        rd(4, "R7 A high");
        rd(5, "R7 B high");

        // R10 core loads and flags
        core_pulse(2'b01, 2'b10, 2'b11, 16'h9911, 16'h7755);
        rd(2, "R10 core A low");
        rd(3, "R10 B low untouched");
        rd(4, "R10 A high untouched");
        rd(5, "R10 core B high");
        rd(0, "R10 flags");

        // R11 host priority
        wr(1, 8'h03);
        bus_cycle(1'b1, 2, 8'h47, 2'b11, 2'b00, 2'b00, 16'h8822, 16'h0, "write");
        rd(2, "R11 A low host wins");
        rd(3, "R11 B low core load");
        bus_cycle(1'b1, 0, 8'h00, 2'b00, 2'b00, 2'b11, 16'h0, 16'h0, "write");
        rd(0, "R11 ctrl host wins");
        bus_cycle(1'b1, 5, 8'h12, 2'b00, 2'b10, 2'b00, 16'h0, 16'hEE00, "write");
        rd(5, "R11 B high host wins");

        // R9 unused offsets
        wr(6, 8'hFF);
        wr(7, 8'hAB);
        rd(6, "R9 offset 6");
        rd(7, "R9 offset 7");
        for (int i = 0; i < 6; i++) rd(i, "R9 regs unchanged");

        repeat (4) @(negedge clk);
        check("R2 all acks seen", 32'(q_exp.size()), 32'd0);
        finish_run();
    end

endmodule